// File: doc/BRIEF.md
# Translation Fault Status Capture Unit

This block records address-translation faults for a set of translation contexts. A translation engine, outside this block, reports each fault as a single event. The event carries the target context, a set of fault-kind flags, a three-bit error code, a two-bit table level and the full 64-bit I/O address that faulted. Each context keeps one status word and a pair of 32-bit error-address words. Software reads these words through a plain register port that uses a context index and a byte offset.

When an idle context takes a fault, the context captures the whole event. While a context still holds an unserviced fault, later faults only add their flag bits. The first code, level and address stay in place. Software reads the address words first and then writes zero to the status word. That single write clears the status and also wipes the address words, so an address read after the clear returns zero.

Each context drives its own interrupt when its enable pin is high and any flag is set. One summary interrupt, delayed by one register stage, is the OR of the per-context interrupts. The fault input is a valid/ready stream. The block applies no back-pressure: ready is held high, and an event is taken on every clock edge where valid is high.

Top module: `fault_capture`

## Requirements
- R1: After reset, every context reads zero at offsets 0x20, 0x30 and 0x34, and both `ctx_irq` and `irq` are low.
- R2: A fault with at least one flag, sent to a context whose flags are all clear, is captured. The status word at offset 0x20 then holds: translation fault in bit 0, page fault in bit 1, walk abort in bit 2, multiple hit in bit 4, error code in bits 10:8, and table level in bits 13:12. All other bits read zero. The captured value is readable on the cycle after the event is accepted. Input flag order is `flt_flags[0]` translation, `[1]` page, `[2]` abort, `[3]` multiple hit.
- R3: The captured address reads back with bits 31:0 at offset 0x30 and bits 63:32 at offset 0x34.
- R4: A fault sent to a context that already has a flag set ORs its flags into the status word. It leaves the code, the level and both address words unchanged.
- R5: Writing zero to offset 0x20 of a context clears its status word and both of its address words to zero.
- R6: Writing a nonzero value to offset 0x20 has no effect. Writes to offsets 0x30 and 0x34 also have no effect.
- R7: `ctx_irq[c]` is high exactly when `ctx_irq_en[c]` is high and context c has any flag set.
- R8: `irq` equals the OR of `ctx_irq`, delayed by one clock cycle.
- R9: When a fault and a zero write reach the same context in the same cycle, the context ends up holding the new fault as a fresh capture.
- R10: A fault event whose four flags are all zero changes nothing.
- R11: A fault sent to one context leaves the status and address words of every other context unchanged.
- R12: `flt_ready` is high whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault event valid |
| flt_ready | output | 1 | Fault event ready, held high |
| flt_ctx | input | CW | Target context index |
| flt_flags | input | 4 | Fault kinds: translation, page, abort, multiple hit |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Table level of the error |
| flt_addr | input | 64 | Faulting I/O address |
| ctx_irq_en | input | NCTX | Per-context interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_ctx | input | CW | Register access context index |
| reg_off | input | 8 | Byte offset within the context |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from index and offset |
| ctx_irq | output | NCTX | Per-context interrupt |
| irq | output | 1 | Registered OR of all context interrupts |

## Verification
An event or write accepted at clock edge E is visible on `reg_rdata` and `ctx_irq` immediately after E. `irq` follows one edge later, at E+1. The driver applies stimulus just after a rising edge and queues the expected read value. The monitor compares that value at the next falling edge, so every register sample falls after the edge that updated the state. Interrupt checks sample `ctx_irq` and `irq` just after E and again after E+1, which confirms the one-cycle lag.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned STAT_W  = 14;
  localparam int unsigned OFF_W   = 8;

  localparam logic [OFF_W-1:0] OFF_STATUS  = 8'h20;
  localparam logic [OFF_W-1:0] OFF_ADDR_LO = 8'h30;
  localparam logic [OFF_W-1:0] OFF_ADDR_HI = 8'h34;

  typedef struct packed {
    logic [LVL_W-1:0]  level;
    logic [CODE_W-1:0] code;
    logic [FLAG_W-1:0] flags;
  } fault_info_t;

  // Place the four flags and the code/level fields into the status layout.
  function automatic logic [STAT_W-1:0] pack_status(fault_info_t f);
    logic [STAT_W-1:0] s;
    s        = '0;
    s[2:0]   = f.flags[2:0];
    s[4]     = f.flags[3];
    s[10:8]  = f.code;
    s[13:12] = f.level;
    return s;
  endfunction
endpackage

// File: rtl/fault_ctx_slot.sv
module fault_ctx_slot
  import fault_capture_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  fault_info_t         info,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic                clr,
  input  logic                irq_en,
  output logic [STAT_W-1:0]   stat,
  output logic [ADDR_W-1:0]   addr_q,
  output logic                irq
);
  fault_info_t held_q;
  logic        busy;
  logic        take;

  assign busy = |held_q.flags;
  assign take = hit && (|info.flags);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      if (busy && !clr) begin
        held_q.flags <= held_q.flags | info.flags;
      end else begin
        held_q <= info;
        addr_q <= addr_in;
      end
    end else if (clr) begin
      held_q <= '0;
      addr_q <= '0;
    end
  end

  assign stat = pack_status(held_q);
  assign irq  = irq_en && busy;
endmodule

// File: rtl/fault_reg_mux.sv
module fault_reg_mux
  import fault_capture_pkg::*;
#(
  parameter int unsigned NCTX = 4,
  localparam int unsigned CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic [NCTX-1:0][STAT_W-1:0] stat_all,
  input  logic [NCTX-1:0][ADDR_W-1:0] addr_all,
  input  logic [CW-1:0]               sel_ctx,
  input  logic [OFF_W-1:0]            sel_off,
  output logic [REG_W-1:0]            rdata
);
  logic [STAT_W-1:0] s;
  logic [ADDR_W-1:0] a;
  logic              in_range;

  assign in_range = 32'(sel_ctx) < NCTX;

  always_comb begin
    s = '0;
    a = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (in_range && sel_ctx == CW'(i)) begin
        s = stat_all[i];
        a = addr_all[i];
      end
    end
    case (sel_off)
      OFF_STATUS:  rdata = {{(REG_W-STAT_W){1'b0}}, s};
      OFF_ADDR_LO: rdata = a[REG_W-1:0];
      OFF_ADDR_HI: rdata = a[ADDR_W-1:REG_W];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_irq_merge.sv
module fault_irq_merge #(
  parameter int unsigned NCTX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] src,
  output logic            merged
);
  always_ff @(posedge clk) begin
    if (!rst_n) merged <= 1'b0;
    else        merged <= |src;
  end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import fault_capture_pkg::*;
#(
  parameter int unsigned NCTX = 4,
  localparam int unsigned CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [CW-1:0]     flt_ctx,
  input  logic [3:0]        flt_flags,
  input  logic [2:0]        flt_code,
  input  logic [1:0]        flt_level,
  input  logic [63:0]       flt_addr,
  input  logic [NCTX-1:0]   ctx_irq_en,
  input  logic              reg_wr,
  input  logic [CW-1:0]     reg_ctx,
  input  logic [7:0]        reg_off,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCTX-1:0]   ctx_irq,
  output logic              irq
);
  logic [NCTX-1:0][STAT_W-1:0] stat_w;
  logic [NCTX-1:0][ADDR_W-1:0] addr_w;
  fault_info_t                 info;
  logic                        zero_wr;

  assign flt_ready = 1'b1;
  assign info      = '{level: flt_level, code: flt_code, flags: flt_flags};
  assign zero_wr   = reg_wr && (reg_off == OFF_STATUS) && (reg_wdata == '0);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic hit_c, clr_c;
    assign hit_c = flt_valid && flt_ready && (flt_ctx == CW'(c));
    assign clr_c = zero_wr && (reg_ctx == CW'(c));

    fault_ctx_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_c),
      .info    (info),
      .addr_in (flt_addr),
      .clr     (clr_c),
      .irq_en  (ctx_irq_en[c]),
      .stat    (stat_w[c]),
      .addr_q  (addr_w[c]),
      .irq     (ctx_irq[c])
    );
  end

  fault_reg_mux #(.NCTX(NCTX)) u_mux (
    .stat_all (stat_w),
    .addr_all (addr_w),
    .sel_ctx  (reg_ctx),
    .sel_off  (reg_off),
    .rdata    (reg_rdata)
  );

  fault_irq_merge #(.NCTX(NCTX)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (ctx_irq),
    .merged (irq)
  );
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk
  import fault_capture_pkg::*;
#(
  parameter int unsigned NCTX = 4,
  localparam int unsigned CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flt_valid,
  input logic                        flt_ready,
  input logic [CW-1:0]               flt_ctx,
  input logic [3:0]                  flt_flags,
  input logic [63:0]                 flt_addr,
  input logic [NCTX-1:0]             ctx_irq_en,
  input logic                        reg_wr,
  input logic [CW-1:0]               reg_ctx,
  input logic [7:0]                  reg_off,
  input logic [31:0]                 reg_wdata,
  input logic [NCTX-1:0]             ctx_irq,
  input logic                        irq,
  input logic [NCTX-1:0][STAT_W-1:0] stat_w,
  input logic [NCTX-1:0][ADDR_W-1:0] addr_w
);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) flt_ready);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_irq & ~ctx_irq_en) == '0);

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|ctx_irq));

  for (genvar c = 0; c < NCTX; c++) begin : g_c
    logic hit_c, zclr_c, nzw_c, set_c;
    assign hit_c  = flt_valid && (flt_ctx == CW'(c)) && (|flt_flags);
    assign zclr_c = reg_wr && reg_ctx == CW'(c) && reg_off == OFF_STATUS && reg_wdata == '0;
    assign nzw_c  = reg_wr && reg_ctx == CW'(c) && reg_off == OFF_STATUS && reg_wdata != '0;
    assign set_c  = |{stat_w[c][4], stat_w[c][2:0]};

    // R4
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_c && !zclr_c) |=> ($stable(addr_w[c]) && $stable(stat_w[c][13:8])));

    // R5
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zclr_c && !hit_c) |=> (stat_w[c] == '0 && addr_w[c] == '0));

    // R6
    nonzero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nzw_c && !hit_c) |=> $stable(stat_w[c]));

    // R9
    clear_and_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zclr_c && hit_c) |=> addr_w[c] == $past(flt_addr));
  end
endmodule

bind fault_capture fault_capture_chk #(.NCTX(NCTX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_valid  (flt_valid),
  .flt_ready  (flt_ready),
  .flt_ctx    (flt_ctx),
  .flt_flags  (flt_flags),
  .flt_addr   (flt_addr),
  .ctx_irq_en (ctx_irq_en),
  .reg_wr     (reg_wr),
  .reg_ctx    (reg_ctx),
  .reg_off    (reg_off),
  .reg_wdata  (reg_wdata),
  .ctx_irq    (ctx_irq),
  .irq        (irq),
  .stat_w     (stat_w),
  .addr_w     (addr_w)
);

// File: tb/fault_capture_bench.sv
module fault_capture_bench;
  localparam int NCTX = 4;
  localparam int CW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_valid = 1'b0;
  logic flt_ready;
  logic [CW-1:0] flt_ctx = '0;
  logic [3:0] flt_flags = '0;
  logic [2:0] flt_code = '0;
  logic [1:0] flt_level = '0;
  logic [63:0] flt_addr = '0;
  logic [NCTX-1:0] ctx_irq_en = '0;
  logic reg_wr = 1'b0;
  logic [CW-1:0] reg_ctx = '0;
  logic [7:0] reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCTX-1:0] ctx_irq;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_go = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  fault_capture #(.NCTX(NCTX)) u_fault_capture (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read results appear
  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      mon_go = 0;
    end
  end

  task automatic expect_rd(int ctx, logic [7:0] off, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_ctx = CW'(ctx);
    reg_off = off;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    mon_go = 1;
    @(negedge clk); #1;
  endtask

  task automatic fault(int ctx, logic [3:0] fl, logic [2:0] cd, logic [1:0] lv, logic [63:0] a);
    @(posedge clk); #1;
    flt_valid = 1; flt_ctx = CW'(ctx); flt_flags = fl; flt_code = cd; flt_level = lv; flt_addr = a;
    @(posedge clk); #1;
    flt_valid = 0;
  endtask

  task automatic wr(int ctx, logic [7:0] off, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_ctx = CW'(ctx); reg_off = off; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_rd(0, 8'h20, 32'h0, "R1 status");
    expect_rd(3, 8'h34, 32'h0, "R1 addr hi");
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R12 ready", {31'b0, flt_ready}, 32'h1);

    ctx_irq_en = 4'b0011;
    fault(1, 4'b0001, 3'd4, 2'd2, 64'h0000_00AB_1234_5000);
    check("R7 ctx_irq set", {28'b0, ctx_irq}, 32'h2);
    check("R8 irq lags", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R8 irq up", {31'b0, irq}, 32'h1);
    expect_rd(1, 8'h20, 32'h0000_2401, "R2 status");
    expect_rd(1, 8'h30, 32'h1234_5000, "R3 addr lo");
    expect_rd(1, 8'h34, 32'h0000_00AB, "R3 addr hi");

    fault(1, 4'b1000, 3'd5, 2'd1, 64'h0000_0011_0000_0000);
    expect_rd(1, 8'h20, 32'h0000_2411, "R4 flags merged");
    expect_rd(1, 8'h34, 32'h0000_00AB, "R4 addr kept");

    wr(1, 8'h20, 32'h0000_2411);
    expect_rd(1, 8'h20, 32'h0000_2411, "R6 nonzero write");
    wr(1, 8'h30, 32'hFFFF_FFFF);
    expect_rd(1, 8'h30, 32'h1234_5000, "R6 addr write");

    fault(2, 4'b0010, 3'd1, 2'd3, 64'h0000_0002_CAFE_0000);
    check("R7 disabled ctx", {28'b0, ctx_irq}, 32'h2);
    expect_rd(2, 8'h20, 32'h0000_3102, "R2 page fault");
    expect_rd(1, 8'h20, 32'h0000_2411, "R11 other ctx");

    wr(1, 8'h20, 32'h0);
    check("R7 cleared", {28'b0, ctx_irq}, 32'h0);
    expect_rd(1, 8'h20, 32'h0, "R5 status");
    expect_rd(1, 8'h30, 32'h0, "R5 addr lo");
    expect_rd(1, 8'h34, 32'h0, "R5 addr hi");
    check("R8 irq down", {31'b0, irq}, 32'h0);

    fault(0, 4'b0000, 3'd7, 2'd3, 64'hFFFF_0000_0000_0001);
    expect_rd(0, 8'h20, 32'h0, "R10 empty event");
    expect_rd(0, 8'h30, 32'h0, "R10 addr");

    @(posedge clk); #1;
    flt_valid = 1; flt_ctx = 2; flt_flags = 4'b0100; flt_code = 0; flt_level = 0;
    flt_addr = 64'h0000_0009_8765_4320;
    reg_wr = 1; reg_ctx = 2; reg_off = 8'h20; reg_wdata = 0;
    @(posedge clk); #1;
    flt_valid = 0; reg_wr = 0;
    expect_rd(2, 8'h20, 32'h0000_0004, "R9 fresh status");
    expect_rd(2, 8'h30, 32'h8765_4320, "R9 fresh addr");

    ctx_irq_en = 4'b0100; #1;
    check("R7 enable late", {28'b0, ctx_irq}, 32'h4);
    repeat (2) @(posedge clk); #1;
    finish_run();
  end
endmodule